// File: doc/BRIEF.md
# Wait/Stop Low-Power Mode Controller

This block puts a small 8-bit CPU core to sleep and wakes it again. Decoded strobes from the instruction decoder ask for one of two sleep levels. A light sleep (wait) only gates the CPU clock. A deep sleep (stop) also turns the oscillator off. The controller owns the interrupt-mask bit across these transitions. Both sleep levels clear the mask on entry. On the way out, the wake source decides the final value of the mask: an interrupt leaves it clear, and a reset sets it.

A light sleep ends on any enabled interrupt, internal or external, and the clock comes back on the next cycle. A light sleep also ends on an enabled break request; the controller then raises a status flag, which software reads to correct its return address. A deep sleep ignores internal interrupts and break requests, and ends only on an external interrupt or a reset. After an external wake from deep sleep, the oscillator is restarted and a stabilization counter must expire before the CPU clock is enabled again. Reset overrides every other input and returns the core to run mode in one cycle.

Top module: `pwrmode_seq`

## Requirements
- R1: With `rst` high at a clock edge, in the next cycle `pm_mode` is 2'b00 (run), `cpu_clk_en` is 1, `osc_stop` is 0, `imask` is 1 and `brk_wait_flag` is 0. This holds whatever the other inputs are, including a wake or a strobe in the same cycle.
- R2: In run mode, `wait_stb` (with `stop_stb` low) at a clock edge gives, in the next cycle: `pm_mode` 2'b01 (wait), `cpu_clk_en` 0, `osc_stop` 0 and `imask` 0.
- R3: In run mode, `stop_stb` at a clock edge gives, in the next cycle: `pm_mode` 2'b10 (stop), `cpu_clk_en` 0, `osc_stop` 1 and `imask` 0. When `stop_stb` and `wait_stb` are high together, stop is taken.
- R4: In wait mode, `irq_int` or `irq_ext` at a clock edge gives run mode with `cpu_clk_en` 1 in the next cycle, and `imask` stays 0.
- R5: In stop mode, `irq_int` and a break request (`brk_en` and `brk_req`) leave `pm_mode`, `osc_stop` and `brk_wait_flag` unchanged.
- R6: In stop mode, `irq_ext` at a clock edge gives `pm_mode` 2'b11 (stabilizing) with `osc_stop` 0 and `cpu_clk_en` 0. This lasts exactly `STAB_CYCLES` cycles. The block then returns to run mode with `cpu_clk_en` 1 and `imask` 0.
- R7: In wait mode, `brk_req` with `brk_en` high wakes the core to run mode in the next cycle and sets `brk_wait_flag`. With `brk_en` low, the request has no effect.
- R8: `flag_wr` with `flag_wdata` 0 clears `brk_wait_flag` in the next cycle. A write of 1 has no effect. A flag set in the same cycle as a clear wins.
- R9: In run mode, with no strobe, `imask_wr` loads `imask_wdata` into `imask` for the next cycle. The write is ignored outside run mode. A strobe in the same cycle wins over the write.
- R10: `wait_stb` and `stop_stb` are ignored in wait, stop and stabilizing modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst | input | 1 | Synchronous active-high reset and reset wake source |
| wait_stb | input | 1 | Decoded light-sleep instruction strobe |
| stop_stb | input | 1 | Decoded deep-sleep instruction strobe |
| irq_int | input | 1 | Enabled interrupt request from an on-chip source |
| irq_ext | input | 1 | Enabled interrupt request from an external pin |
| brk_en | input | 1 | Break logic enabled |
| brk_req | input | 1 | Break match request |
| flag_wr | input | 1 | Software write strobe for the break flag |
| flag_wdata | input | 1 | Data written to the break flag (only 0 acts) |
| imask_wr | input | 1 | Core write strobe for the interrupt mask |
| imask_wdata | input | 1 | Value written to the interrupt mask |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_stop | output | 1 | Oscillator shut-down request |
| imask | output | 1 | Interrupt-mask bit |
| brk_wait_flag | output | 1 | Break-taken-during-wait status |
| pm_mode | output | 2 | Current mode: 00 run, 01 wait, 10 stop, 11 stabilizing |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is the break wake, which sets the status flag, and a software clear of that flag. The bench provokes it by holding a clear write in the cycle where a break request arrives in wait mode, and expects the flag to read 1 afterwards. The second pair is a reset arriving together with an interrupt wake or a strobe. The bench judges this against its behavioural model, which expects run mode with the mask set rather than the interrupt outcome with the mask clear.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'b00,
        PM_WAIT = 2'b01,
        PM_STOP = 2'b10,
        PM_STAB = 2'b11
    } pm_mode_e;

    // qualified wake requests seen by the mode sequencer
    typedef struct packed {
        logic irq_any;
        logic irq_pin;
        logic brk;
    } wake_req_t;

    // one-cycle events produced by the sequencer
    typedef struct packed {
        logic enter_wait;
        logic enter_stop;
        logic wake_irq;
        logic wake_brk;
        logic stab_start;
    } pm_evt_t;

    function automatic logic clock_running(input pm_mode_e m);
        return (m == PM_RUN);
    endfunction

    function automatic logic osc_halted(input pm_mode_e m);
        return (m == PM_STOP);
    endfunction

endpackage

// File: rtl/pm_stab_timer.sv
module pm_stab_timer #(
    parameter int STAB_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic active,
    output logic done
);
    localparam int CNT_W = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(STAB_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= LOAD;
        else if (active && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = active && (cnt == '0);

    // independent length observer for the stabilization window
    int unsigned obs;
    always_ff @(posedge clk) begin
        if (rst || start)
            obs <= 0;
        else if (active)
            obs <= obs + 1;
    end

    // R6: done fires only after exactly STAB_CYCLES-1 active cycles
    p_stab_len_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (obs == STAB_CYCLES - 1));

    p_start_loads_r6: assert property (@(posedge clk) disable iff (rst)
        start |=> (cnt == LOAD));

endmodule

// File: rtl/pm_fsm.sv
module pm_fsm
    import pwrmode_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wait_stb,
    input  logic      stop_stb,
    input  wake_req_t wreq,
    input  logic      stab_done,
    output pm_mode_e  mode,
    output pm_evt_t   evt
);
    pm_mode_e nxt;

    always_comb begin
        nxt = mode;
        evt = '0;
        unique case (mode)
            PM_RUN: begin
                if (stop_stb) begin
                    nxt = PM_STOP;
                    evt.enter_stop = 1'b1;
                end else if (wait_stb) begin
                    nxt = PM_WAIT;
                    evt.enter_wait = 1'b1;
                end
            end
            PM_WAIT: begin
                evt.wake_irq = wreq.irq_any;
                evt.wake_brk = wreq.brk;
                if (wreq.irq_any || wreq.brk)
                    nxt = PM_RUN;
            end
            PM_STOP: begin
                if (wreq.irq_pin) begin
                    nxt = PM_STAB;
                    evt.stab_start = 1'b1;
                end
            end
            PM_STAB: begin
                if (stab_done)
                    nxt = PM_RUN;
            end
            default: nxt = PM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode <= PM_RUN;
        else
            mode <= nxt;
    end

    // R1: reset returns to run mode in one cycle
    p_rst_run_r1: assert property (@(posedge clk)
        rst |=> (mode == PM_RUN));

    // R3: stop strobe from run enters stop, even with wait strobe
    p_stop_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_RUN && stop_stb) |=> (mode == PM_STOP));

    // R5: without an external request, stop mode persists
    p_stop_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_STOP && !wreq.irq_pin) |=> (mode == PM_STOP));

    // R4: any interrupt in wait returns to run
    p_wait_wake_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_WAIT && wreq.irq_any) |=> (mode == PM_RUN));

    // R10: strobes do nothing outside run
    p_stb_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_STAB && !stab_done) |=> (mode == PM_STAB));

endmodule

// File: rtl/pm_imask.sv
module pm_imask
    import pwrmode_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pm_evt_t evt,
    input  logic    in_run,
    input  logic    wr,
    input  logic    wdata,
    output logic    imask
);
    logic entering;
    assign entering = evt.enter_wait || evt.enter_stop;

    always_ff @(posedge clk) begin
        if (rst)
            imask <= 1'b1;
        else if (entering)
            imask <= 1'b0;
        else if (in_run && wr)
            imask <= wdata;
    end

    // R2 / R3: sleep entry clears the mask
    p_entry_clears_r2: assert property (@(posedge clk) disable iff (rst)
        entering |=> !imask);

    // R4: an interrupt wake leaves the mask clear
    p_wake_keeps_r4: assert property (@(posedge clk) disable iff (rst)
        evt.wake_irq |=> !imask);

    // R1: reset sets the mask
    p_rst_sets_r1: assert property (@(posedge clk)
        rst |=> imask);

endmodule

// File: rtl/pm_brkflag.sv
module pm_brkflag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic wr,
    input  logic wdata,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (wr && !wdata)
            flag <= 1'b0;
    end

    // R7: a break taken in wait sets the flag
    p_set_r7: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);

    // R8: writing 1 never changes the flag on its own
    p_w1_noeffect_r8: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata && !set) |=> (flag == $past(flag)));

endmodule

// File: rtl/pwrmode_seq.sv
module pwrmode_seq
    import pwrmode_pkg::*;
#(
    parameter int STAB_CYCLES = 4096
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wait_stb,
    input  logic       stop_stb,
    input  logic       irq_int,
    input  logic       irq_ext,
    input  logic       brk_en,
    input  logic       brk_req,
    input  logic       flag_wr,
    input  logic       flag_wdata,
    input  logic       imask_wr,
    input  logic       imask_wdata,
    output logic       cpu_clk_en,
    output logic       osc_stop,
    output logic       imask,
    output logic       brk_wait_flag,
    output logic [1:0] pm_mode
);
    wake_req_t wreq;
    pm_evt_t   evt;
    pm_mode_e  mode;
    logic      stab_done;

    always_comb begin
        wreq.irq_any = irq_int || irq_ext;
        wreq.irq_pin = irq_ext;
        wreq.brk     = brk_en && brk_req;
    end

    pm_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .wait_stb (wait_stb),
        .stop_stb (stop_stb),
        .wreq     (wreq),
        .stab_done(stab_done),
        .mode     (mode),
        .evt      (evt)
    );

    pm_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (evt.stab_start),
        .active(mode == PM_STAB),
        .done  (stab_done)
    );

    pm_imask u_imask (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .in_run(mode == PM_RUN),
        .wr    (imask_wr),
        .wdata (imask_wdata),
        .imask (imask)
    );

    pm_brkflag u_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (evt.wake_brk),
        .wr   (flag_wr),
        .wdata(flag_wdata),
        .flag (brk_wait_flag)
    );

    assign cpu_clk_en = clock_running(mode);
    assign osc_stop   = osc_halted(mode);
    assign pm_mode    = mode;

    // R6: clock stays off while the oscillator settles
    p_stab_clk_off_r6: assert property (@(posedge clk) disable iff (rst)
        (pm_mode == 2'b10 && irq_ext) |=> (!cpu_clk_en && !osc_stop));

    // R5: stop mode ignores break requests for the flag
    p_stop_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (pm_mode == 2'b10 && !flag_wr) |=> $stable(brk_wait_flag));

endmodule

// File: tb/pwrmode_seq_bench.sv
module pwrmode_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_STAB = 4096;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wait_stb = 0, stop_stb = 0, irq_int = 0, irq_ext = 0;
    logic brk_en = 0, brk_req = 0, flag_wr = 0, flag_wdata = 0;
    logic imask_wr = 0, imask_wdata = 0;
    logic cpu_clk_en, osc_stop, imask, brk_wait_flag;
    logic [1:0] pm_mode;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrmode_seq #(.STAB_CYCLES(N_STAB)) u_pwrmode_seq (
        .clk(clk), .rst(rst), .wait_stb(wait_stb), .stop_stb(stop_stb),
        .irq_int(irq_int), .irq_ext(irq_ext), .brk_en(brk_en), .brk_req(brk_req),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata), .imask_wr(imask_wr),
        .imask_wdata(imask_wdata), .cpu_clk_en(cpu_clk_en), .osc_stop(osc_stop),
        .imask(imask), .brk_wait_flag(brk_wait_flag), .pm_mode(pm_mode)
    );

    // behavioural reference state
    int m_mode = 0;   // 0 run, 1 wait, 2 stop, 3 stabilizing
    int m_cnt  = 0;
    bit m_im   = 1;
    bit m_flag = 0;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit done = 0;

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
            summary();
        end
    end

    task automatic model_edge();
        bit set;
        if (rst) begin
            m_mode = 0; m_im = 1; m_flag = 0; m_cnt = 0;
            return;
        end
        set = 0;
        case (m_mode)
            0: begin
                if (stop_stb) begin m_mode = 2; m_im = 0; end
                else if (wait_stb) begin m_mode = 1; m_im = 0; end
                else if (imask_wr) m_im = imask_wdata;
            end
            1: begin
                if (brk_en && brk_req) set = 1;
                if (irq_int || irq_ext || (brk_en && brk_req)) m_mode = 0;
            end
            2: if (irq_ext) begin m_mode = 3; m_cnt = N_STAB; end
            default: begin
                m_cnt--;
                if (m_cnt == 0) m_mode = 0;
            end
        endcase
        if (set) m_flag = 1;
        else if (flag_wr && !flag_wdata) m_flag = 0;
    endtask

    task automatic compare(input string tag);
        logic [5:0] act, exp;
        act = {pm_mode, cpu_clk_en, osc_stop, imask, brk_wait_flag};
        exp = {2'(m_mode), (m_mode == 0), (m_mode == 2), m_im, m_flag};
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual mode/clk/osc/im/flag=%b expected %b", tag, act, exp);
        end
    endtask

    // drive at negedge, apply edge, compare at next negedge
    task automatic step(input logic r, ws, ss, ii, ie, be, br, fw, fd, iw, id,
                        input string tag);
        rst = r; wait_stb = ws; stop_stb = ss; irq_int = ii; irq_ext = ie;
        brk_en = be; brk_req = br; flag_wr = fw; flag_wdata = fd;
        imask_wr = iw; imask_wdata = id;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input string tag);
        step(0,0,0,0,0,0,0,0,0,0,0, tag);
    endtask

    initial begin
        @(negedge clk);
        step(1,0,0,0,0,0,0,0,0,0,0, "R1 reset");
        step(1,1,1,1,1,1,1,0,0,1,0, "R1 reset with all inputs");
        idle("R1 run after reset");
        // R9 mask writes in run
        step(0,0,0,0,0,0,0,0,0,1,0, "R9 write 0");
        step(0,0,0,0,0,0,0,0,0,1,1, "R9 write 1");
        // R2 wait entry, R10 strobes ignored, R4 internal wake
        step(0,1,0,0,0,0,0,0,0,0,0, "R2 wait entry");
        step(0,0,0,0,0,0,0,0,0,1,1, "R9 write ignored in wait");
        step(0,1,1,0,0,0,0,0,0,0,0, "R10 strobes in wait");
        step(0,0,0,1,0,0,0,0,0,0,0, "R4 internal wake");
        idle("R4 running");
        // R9 strobe beats write
        step(0,1,0,0,0,0,0,0,0,1,1, "R9 strobe wins over write");
        step(0,0,0,0,1,0,0,0,0,0,0, "R4 external wake");
        // R7 break in wait
        step(0,1,0,0,0,0,0,0,0,0,0, "R2 wait entry");
        step(0,0,0,0,0,0,1,0,0,0,0, "R7 break disabled");
        step(0,0,0,0,0,1,1,0,0,0,0, "R7 break wake");
        step(0,0,0,0,0,0,0,1,1,0,0, "R8 write 1 no effect");
        step(0,0,0,0,0,0,0,1,0,0,0, "R8 write 0 clears");
        step(0,1,0,0,0,0,0,0,0,0,0, "R2 wait entry");
        step(0,0,0,1,0,1,1,1,0,0,0, "R8 set beats clear");
        idle("R8 flag held");
        // R3 stop with both strobes, R5 qualification
        step(0,1,1,0,0,0,0,0,0,0,0, "R3 stop wins");
        step(0,0,0,1,0,0,0,0,0,0,0, "R5 internal irq in stop");
        step(0,0,0,0,0,1,1,0,0,0,0, "R5 break in stop");
        step(0,1,1,0,0,0,0,0,0,1,1, "R10 strobes in stop");
        step(0,0,0,0,1,0,0,0,0,0,0, "R6 external wake");
        for (int i = 0; i < N_STAB - 1; i++) begin
            if (i == 5) step(0,1,1,1,1,0,0,0,0,0,0, "R10 strobes in stab");
            else idle("R6 stabilizing");
        end
        idle("R6 run after stab");
        idle("R6 run");
        // R1 reset during stabilization
        step(0,0,1,0,0,0,0,0,0,0,0, "R3 stop entry");
        step(0,0,0,0,1,0,0,0,0,0,0, "R6 wake");
        idle("R6 stabilizing");
        step(1,0,0,0,0,0,0,0,0,0,0, "R1 reset in stab");
        // R1 reset together with an interrupt wake
        step(0,1,0,0,0,0,0,0,0,0,0, "R2 wait entry");
        step(1,0,0,1,1,1,1,0,0,0,0, "R1 reset beats wake");
        step(0,0,1,0,0,0,0,0,0,0,0, "R3 stop entry");
        step(1,0,0,0,0,0,0,0,0,0,0, "R1 reset in stop");
        idle("R1 run");
        summary();
    end
endmodule